// File: doc/BRIEF.md
# Overcurrent Fault Latch for a Three-Phase Gate Stage

This block sits between the drive commands for a three-phase motor bridge and the gate-driver stage. Each clock it receives a digitized peak phase-current code and six requested gate levels, two per half-bridge. While the current stays in range the gate requests pass through unchanged. Once the current goes above the trip level, the block pulls its active-low fault line low and forces every gate output low, which turns all six switches off.

The fault condition is kept entirely in hardware. It stays set for any length of time without further stimulus, and it ends only when the controlling processor raises a clear request while the current is back in range. After the latch clears, the gate outputs stay off for one more cycle before they follow their commands again. At a 50 MHz clock the path from a sampled overcurrent to the fault output takes two clock edges (40 ns), which is far inside the 5 µs response budget.

Top module: `oc_fault_latch`

## Requirements
- R1: The current is a 12-bit unsigned code at 0.1 A per LSB. A code strictly above 600 (60.0 A) is an overcurrent. A code of 600 or less is not.
- R2: An overcurrent code presented before clock edge k makes fault_n_o low after edge k+1, which is two edges later.
- R3: fault_n_o is active-low. It is high whenever the latch is not faulted, and it is high while reset is applied.
- R4: While fault_n_o is low, all six bits of gate_o are 0 whatever gate_cmd_i requests.
- R5: Once set, the fault stays set for any number of cycles while clr_req_i is low, with no other input activity needed.
- R6: A clear request is taken at an edge only when two conditions hold: the code sampled at the previous edge was not an overcurrent, and the code present at this edge is not an overcurrent. Otherwise the request is ignored and the fault stays set. A new overcurrent reaching the latch at the same edge as a request always wins.
- R7: In the cycle after the latch clears, fault_n_o is high but gate_o is still all 0. From the following cycle on, gate_o follows gate_cmd_i.
- R8: When not faulted, gate_o equals gate_cmd_i bit for bit. Bit 2p is the high-side switch and bit 2p+1 is the low-side switch of half-bridge p. A clear request has no effect while not faulted.
- R9: Asserting rst_ni low at once sets fault_n_o high and gate_o to 0. After rst_ni rises, gate_o stays 0 through two clock edges and follows gate_cmd_i after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock (50 MHz nominal) |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cur_code_i | input | 12 | Peak phase-current code, 0.1 A per LSB |
| gate_cmd_i | input | 6 | Requested gate levels, bit 2p high side and bit 2p+1 low side of half-bridge p |
| clr_req_i | input | 1 | Fault clear request from the controlling processor |
| gate_o | output | 6 | Gate levels passed to the driver stage, same bit layout |
| fault_n_o | output | 1 | Fault indication, low while the latch is set |

## Verification
The assertions assume that cur_code_i, gate_cmd_i and clr_req_i are synchronous to clk_i and settled at each rising edge. They also assume that a clear request means something only after its effect on the latch state, never by its level alone. The stimulus keeps to this by changing every input only on the falling edge. It holds each value through the next rising edge and samples the outputs a half cycle later. Clear requests are placed deliberately on edges where the registered sample, the present sample, or both are above the trip level, so that every case of the clear rule is covered.

// File: rtl/oc_pkg.sv
package oc_pkg;

  localparam int CUR_W_DEF     = 12;
  localparam int TRIP_CODE_DEF = 600;
  localparam int N_PHASE_DEF   = 3;

  typedef enum logic {
    LATCH_RUN  = 1'b0,
    LATCH_TRIP = 1'b1
  } latch_st_e;

endpackage

// File: rtl/oc_rst_sync.sv
module oc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/oc_cmp.sv
module oc_cmp #(
  parameter int CUR_W     = oc_pkg::CUR_W_DEF,
  parameter int TRIP_CODE = oc_pkg::TRIP_CODE_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CUR_W-1:0] cur_code_i,
  output logic             over_now_o,
  output logic             over_q_o
);

  localparam logic [CUR_W-1:0] TRIP_VAL = CUR_W'(TRIP_CODE);

  logic over_d;
  logic over_q;
  logic cmp_en;

  // strict compare: the trip code itself is still in range
  assign over_now_o = (cur_code_i > TRIP_VAL);
  assign cmp_en     = 1'b1;

  always_comb begin
    over_d = over_q;
    if (cmp_en) begin
      over_d = over_now_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      over_q <= 1'b0;
    end else begin
      over_q <= over_d;
    end
  end

  assign over_q_o = over_q;

endmodule

// File: rtl/oc_latch.sv
module oc_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic over_q_i,
  input  logic over_now_i,
  input  logic clr_i,
  output logic faulted_o
);

  import oc_pkg::*;

  latch_st_e st_q;
  latch_st_e st_d;
  logic      clr_ok;

  // a request clears only when both the registered and the live sample are in range
  assign clr_ok = clr_i && !over_q_i && !over_now_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      LATCH_RUN: begin
        if (over_q_i) begin
          st_d = LATCH_TRIP;
        end
      end
      LATCH_TRIP: begin
        if (clr_ok) begin
          st_d = LATCH_RUN;
        end
      end
      default: st_d = LATCH_TRIP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= LATCH_RUN;
    end else begin
      st_q <= st_d;
    end
  end

  assign faulted_o = (st_q == LATCH_TRIP);

  // R2: a registered overcurrent sets the latch at the next edge
  a_r2_trip_next_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over_q_i |=> faulted_o);

  // R5: without a request the latch holds
  a_r5_hold_no_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (faulted_o && !clr_i) |=> faulted_o);

  // R6: a live overcurrent blocks any clear
  a_r6_no_clear_live_over: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (faulted_o && over_now_i) |=> faulted_o);

  // R6: a registered overcurrent blocks any clear
  a_r6_no_clear_reg_over: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (faulted_o && over_q_i) |=> faulted_o);

endmodule

// File: rtl/oc_gate_mask.sv
module oc_gate_mask #(
  parameter int N_PHASE = oc_pkg::N_PHASE_DEF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 faulted_i,
  input  logic [2*N_PHASE-1:0] cmd_i,
  output logic [2*N_PHASE-1:0] gate_o
);

  logic en_q;
  logic en_d;
  logic pass;

  // enable follows the latch one cycle late, so gates return a cycle after clearing
  always_comb begin
    en_d = !faulted_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
    end else begin
      en_q <= en_d;
    end
  end

  assign pass = en_q && !faulted_i;

  for (genvar p = 0; p < N_PHASE; p++) begin : g_leg
    logic hi_s;
    logic lo_s;
    assign hi_s = cmd_i[2*p]   & pass;
    assign lo_s = cmd_i[2*p+1] & pass;
    assign gate_o[2*p]   = hi_s;
    assign gate_o[2*p+1] = lo_s;
  end

  // R7: in the cycle the latch clears the gates are still off
  a_r7_release_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(faulted_i) |-> (gate_o == '0));

endmodule

// File: rtl/oc_fault_latch.sv
module oc_fault_latch #(
  parameter int CUR_W     = oc_pkg::CUR_W_DEF,
  parameter int TRIP_CODE = oc_pkg::TRIP_CODE_DEF,
  parameter int N_PHASE   = oc_pkg::N_PHASE_DEF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CUR_W-1:0]     cur_code_i,
  input  logic [2*N_PHASE-1:0] gate_cmd_i,
  input  logic                 clr_req_i,
  output logic [2*N_PHASE-1:0] gate_o,
  output logic                 fault_n_o
);

  localparam int GATE_W = 2 * N_PHASE;

  logic              rst_n_s;
  logic              over_now;
  logic              over_q;
  logic              faulted;
  logic [GATE_W-1:0] gate_s;

  oc_rst_sync #(
    .STAGES (2)
  ) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_s)
  );

  oc_cmp #(
    .CUR_W     (CUR_W),
    .TRIP_CODE (TRIP_CODE)
  ) u_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_s),
    .cur_code_i (cur_code_i),
    .over_now_o (over_now),
    .over_q_o   (over_q)
  );

  oc_latch u_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_s),
    .over_q_i   (over_q),
    .over_now_i (over_now),
    .clr_i      (clr_req_i),
    .faulted_o  (faulted)
  );

  oc_gate_mask #(
    .N_PHASE (N_PHASE)
  ) u_mask (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .faulted_i (faulted),
    .cmd_i     (gate_cmd_i),
    .gate_o    (gate_s)
  );

  assign gate_o    = gate_s;
  assign fault_n_o = !faulted;

  // R4: fault line low implies every gate off
  a_r4_gates_off: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !fault_n_o |-> (gate_o == '0));

  // R3: during reset the fault line is released and the gates are off
  a_r3_reset_outputs: assert property (@(posedge clk_i)
    !rst_n_s |-> (fault_n_o && gate_o == '0));

endmodule

// File: tb/oc_fault_latch_tb.sv
module oc_fault_latch_tb;

  localparam time CLK_PERIOD = 20ns;
  localparam int  N_VEC      = 26;

  logic        clk;
  logic        rst_n;
  logic [11:0] cur;
  logic [5:0]  cmd;
  logic        clr;
  logic [5:0]  gate;
  logic        fault_n;

  int checks;
  int errors;

  // row: {current code, gate command, clear, expected fault_n, expected gates}
  localparam logic [25:0] VEC [N_VEC] = '{
    {12'd100,  6'h26, 1'b0, 1'b1, 6'h26},  // 0 R8 pass through
    {12'd600,  6'h19, 1'b0, 1'b1, 6'h19},  // 1 R1 at trip code
    {12'd600,  6'h2A, 1'b0, 1'b1, 6'h2A},  // 2 R1 600 not a trip
    {12'd601,  6'h15, 1'b0, 1'b1, 6'h15},  // 3 R2 not yet
    {12'd100,  6'h15, 1'b0, 1'b0, 6'h00},  // 4 R2 second edge
    {12'd100,  6'h3F, 1'b0, 1'b0, 6'h00},  // 5 R5 hold
    {12'd100,  6'h3F, 1'b1, 1'b1, 6'h00},  // 6 R7 cleared, gates still off
    {12'd100,  6'h3F, 1'b0, 1'b1, 6'h3F},  // 7 R7 gates back
    {12'd4095, 6'h0C, 1'b0, 1'b1, 6'h0C},  // 8
    {12'd4095, 6'h0C, 1'b1, 1'b0, 6'h00},  // 9 R1 full scale
    {12'd4095, 6'h0C, 1'b1, 1'b0, 6'h00},  // 10 R6 blocked
    {12'd50,   6'h0C, 1'b1, 1'b0, 6'h00},  // 11 R6 registered over blocks
    {12'd50,   6'h0C, 1'b0, 1'b0, 6'h00},  // 12 R5
    {12'd50,   6'h21, 1'b1, 1'b1, 6'h00},  // 13 R6 clear taken
    {12'd50,   6'h21, 1'b1, 1'b1, 6'h21},  // 14 R8 request while running
    {12'd602,  6'h21, 1'b0, 1'b1, 6'h21},  // 15
    {12'd602,  6'h12, 1'b1, 1'b0, 6'h00},  // 16 R6 trip wins
    {12'd300,  6'h12, 1'b1, 1'b0, 6'h00},  // 17 R6 blocked
    {12'd300,  6'h12, 1'b1, 1'b1, 6'h00},  // 18 R7
    {12'd300,  6'h12, 1'b0, 1'b1, 6'h12},  // 19
    {12'd700,  6'h12, 1'b0, 1'b1, 6'h12},  // 20
    {12'd100,  6'h12, 1'b0, 1'b0, 6'h00},  // 21 R2
    {12'd800,  6'h12, 1'b1, 1'b0, 6'h00},  // 22 R6 live over blocks
    {12'd100,  6'h12, 1'b1, 1'b0, 6'h00},  // 23 R6
    {12'd100,  6'h12, 1'b1, 1'b1, 6'h00},  // 24 R6 clear
    {12'd100,  6'h12, 1'b0, 1'b1, 6'h12}   // 25 R7
  };

  oc_fault_latch u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cur_code_i (cur),
    .gate_cmd_i (cmd),
    .clr_req_i  (clr),
    .gate_o     (gate),
    .fault_n_o  (fault_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [5:0] act_g, input logic [5:0] exp_g,
                     input logic act_f, input logic exp_f);
    checks++;
    if (act_g !== exp_g || act_f !== exp_f) begin
      errors++;
      $display("FAIL %s: gate=%h fault_n=%b, expected gate=%h fault_n=%b",
               req, act_g, act_f, exp_g, exp_f);
    end
  endtask

  // inputs change at a falling edge; sampled at the next falling edge
  task automatic step(input logic [11:0] c, input logic [5:0] g, input logic r);
    cur = c;
    cmd = g;
    clr = r;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    cur = '0;
    cmd = 6'h3F;
    clr = 1'b0;
    #1;
    chk("R9 reset state", gate, 6'h00, fault_n, 1'b1);
    chk("R3 reset fault line", gate, 6'h00, fault_n, 1'b1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) step(12'd0, 6'h00, 1'b0);

    for (int i = 0; i < N_VEC; i++) begin
      logic [25:0] v;
      v = VEC[i];
      step(v[25:14], v[13:8], v[7]);
      chk($sformatf("vector %0d R1/R2/R4/R6/R7/R8", i), gate, v[5:0], fault_n, v[6]);
    end

    // R5: long hold with changing commands and no clear request
    step(12'd900, 6'h3F, 1'b0);
    step(12'd0, 6'h3F, 1'b0);
    chk("R2 trip from 900", gate, 6'h00, fault_n, 1'b0);
    for (int k = 0; k < 40; k++) begin
      step(12'd0, 6'(k), 1'b0);
      chk("R5 hold without software", gate, 6'h00, fault_n, 1'b0);
    end
    step(12'd0, 6'h2D, 1'b1);
    chk("R7 cleared, gates held off", gate, 6'h00, fault_n, 1'b1);
    step(12'd0, 6'h2D, 1'b0);
    chk("R8 follow after clear", gate, 6'h2D, fault_n, 1'b1);

    // R9: reset while faulted, then staged release
    step(12'd1000, 6'h3F, 1'b0);
    step(12'd0, 6'h3F, 1'b0);
    chk("R4 faulted before reset", gate, 6'h00, fault_n, 1'b0);
    rst_n = 1'b0;
    #1;
    chk("R9 async reset clears fault", gate, 6'h00, fault_n, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    step(12'd0, 6'h33, 1'b0);
    chk("R9 release edge 1", gate, 6'h00, fault_n, 1'b1);
    step(12'd0, 6'h33, 1'b0);
    chk("R9 release edge 2", gate, 6'h00, fault_n, 1'b1);
    step(12'd0, 6'h33, 1'b0);
    chk("R9 release edge 3", gate, 6'h33, fault_n, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule